// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer on a small memory-mapped register bus with 16-bit data and single-cycle reads and writes. A countdown runs in ticks of about 10 ms. Each tick is made by dividing a strobe that marks edges of a slow reference clock. Software must keep writing a fixed 16-bit feed key to reload the counter. If it stops, the block first raises a pre-expiry interrupt one tick early. One tick later it drives a system reset pulse and latches a timed-out status that only a power-on reset clears.

Every control action is gated by a 16-bit key value, so a stray write cannot feed, stop or restart the timer. Stopping needs two keys written to two registers in order. Status and enable state read back as multi-bit signature codes. The running count reads back with a flag bit that marks a value which has just changed. A debug-active input freezes the countdown unless software has set an allow bit. Out of reset the timer is stopped, the timeout is 6000 ticks and the interrupt is masked.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset: the enable code at byte offset 0x0C reads 0xDABE (stopped). The timeout at 0x04 reads 6000 (0x1770). The count at 0x14 reads 0x1770. The status at 0x10, mask at 0x24 and event at 0x20 read 0. Unmapped offsets read 0. wdt_irq and wdt_reset are low.
- R2: A write to the timeout register (0x04) stores bits 14:0. Bit 15 always reads 0. Writing the timeout does not reload the counter.
- R3: Writing 0xFEED to the feed register (0x00) reloads the counter from the timeout, restarts the tick prescaler and lets counting run. Any other value written there leaves the count unchanged.
- R4: While counting is allowed, every PRESCALE pulses of ref_pulse make one tick, and each tick lowers the count by one. The change is visible two cycles after the last pulse.
- R5: Writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C stops the timer; 0x0C then reads 0xDABE, and reads 0x0000 while enabled. A 0xCAFE write not directly preceded (among writes to 0x08/0x0C) by a valid 0x2BAD key has no effect. Any other value in either register disarms the sequence. While stopped, the count does not move.
- R6: Writing 0xACED to 0x1C re-enables a stopped timer. Other values are ignored. After re-enabling, the count stays frozen until the next feed key.
- R7: A tick with the count at 0 reloads the counter from the timeout. It drives wdt_reset high for exactly RST_CYCLES cycles and sets the status to 0xCFE8.
- R8: The status reads 0xCFE8 after an expiry and is cleared to 0 only by writing 0xE8B4 to 0x10 or by power-on reset. Other values are ignored, and the block's own reset pulse does not clear it. An expiry wins over a clear in the same cycle.
- R9: The count register (0x14) gives the count in bits 14:0. Bit 15 is 1 for the one cycle after the counter has been loaded or decremented, and 0 otherwise.
- R10: A tick that moves the count from 1 to 0 sets the event bit (0x20 bit 0). wdt_irq equals the event bit ANDed with the mask bit (0x24 bit 0).
- R11: Writing 1 to event bit 0 acknowledges and clears the event. If a pre-expiry or force sets it in the same cycle, the set wins.
- R12: The force register (0x28) bit 0 is read/write. While it is 1, the event bit is held set.
- R13: At 0x18, bit 1 reads the dbg_active input and bit 0 is a read/write allow bit. While dbg_active is 1 and allow is 0, the count is frozen. With allow set, it counts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ref_pulse | input | 1 | One-cycle strobe per reference clock edge |
| dbg_active | input | 1 | Debugger attached; freezes the timer unless allowed |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| wdt_irq | output | 1 | Pre-expiry interrupt |
| wdt_reset | output | 1 | System reset pulse on expiry |

## Verification
Two events can collide in one cycle: a software acknowledge of the interrupt event, and the tick that brings the count from 1 to 0 and raises a new pre-expiry event. The bench brings the count to 1 with a known prescaler phase. It issues the final reference pulse, and in the very next cycle, the one where the decrement lands, it writes the acknowledge. It then expects the event bit to read 1 and the count to read 0. A forced event held through an acknowledge is judged in the same way.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    localparam int CNT_W = 15;
    localparam int DATA_W = 16;

    localparam logic [DATA_W-1:0] KEY_FEED    = 16'hFEED;
    localparam logic [DATA_W-1:0] KEY_STOP_A  = 16'h2BAD;
    localparam logic [DATA_W-1:0] KEY_STOP_B  = 16'hCAFE;
    localparam logic [DATA_W-1:0] KEY_RESUME  = 16'hACED;
    localparam logic [DATA_W-1:0] KEY_STCLR   = 16'hE8B4;
    localparam logic [DATA_W-1:0] SIG_STOPPED = 16'hDABE;
    localparam logic [DATA_W-1:0] SIG_EXPIRED = 16'hCFE8;

    typedef enum logic [3:0] {
        SEL_FEED, SEL_TMO, SEL_STOP_A, SEL_STOP_B, SEL_STAT, SEL_CNT,
        SEL_DBG, SEL_RESUME, SEL_IEVT, SEL_IMSK, SEL_IFRC, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic feed;
        logic tmo;
        logic stop_a;
        logic stop_b;
        logic stat;
        logic dbg;
        logic resume;
        logic ievt;
        logic imsk;
        logic ifrc;
    } wr_strobe_t;

    function automatic reg_sel_e map_addr(input logic [5:0] a, input logic hi_zero);
        reg_sel_e s;
        s = SEL_NONE;
        if (hi_zero && a[1:0] == 2'b00) begin
            case (a[5:2])
                4'd0:  s = SEL_FEED;
                4'd1:  s = SEL_TMO;
                4'd2:  s = SEL_STOP_A;
                4'd3:  s = SEL_STOP_B;
                4'd4:  s = SEL_STAT;
                4'd5:  s = SEL_CNT;
                4'd6:  s = SEL_DBG;
                4'd7:  s = SEL_RESUME;
                4'd8:  s = SEL_IEVT;
                4'd9:  s = SEL_IMSK;
                4'd10: s = SEL_IFRC;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
`timescale 1ns/1ps
module wdt_tick_gen #(
    parameter int PRESCALE = 320
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic restart,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE < 2) begin : g_direct
            assign tick = ref_pulse;
        end else begin : g_div
            logic [PW-1:0] phase;
            logic          tick_q;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    phase  <= '0;
                    tick_q <= 1'b0;
                end else begin
                    tick_q <= 1'b0;
                    if (ref_pulse) begin
                        if (phase == PW'(PRESCALE - 1)) begin
                            phase  <= '0;
                            tick_q <= 1'b1;
                        end else begin
                            phase <= phase + PW'(1);
                        end
                    end
                end
            end
            assign tick = tick_q;

            // R4: ticks are at least PRESCALE reference pulses apart
            assert_tick_spaced_R4: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown #(
    parameter int CNT_W      = 15,
    parameter int RST_CYCLES = 16,
    parameter int TMO_RESET  = 6000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             pre_fire,
    output logic             expire,
    output logic             sys_rst
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic          dec;
    logic [RW-1:0] rst_left;

    always_comb begin
        dec      = tick && run && (cnt != '0);
        expire   = tick && run && (cnt == '0);
        pre_fire = dec && (cnt == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= CNT_W'(TMO_RESET);
            busy     <= 1'b0;
            rst_left <= '0;
        end else begin
            busy <= load || dec || expire;
            if (load || expire)
                cnt <= reload_val;
            else if (dec)
                cnt <= cnt - CNT_W'(1);
            if (expire)
                rst_left <= RW'(RST_CYCLES);
            else if (rst_left != '0)
                rst_left <= rst_left - RW'(1);
        end
    end

    assign sys_rst = (rst_left != '0);

    // R7: expiry reloads from the timeout and starts the reset pulse
    assert_expire_reload_R7: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == $past(reload_val)) && sys_rst);

    // R13, R5: with counting not allowed and no feed, the count holds
    assert_frozen_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt));

    // R9: any change of the count is flagged in the following cycle
    assert_change_flagged_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> busy);
endmodule

// File: rtl/wdt_ctl.sv
`timescale 1ns/1ps
module wdt_ctl
    import wdt_pkg::*;
#(
    parameter int TMO_RESET = 6000
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic              feed_ok,
    output logic              enabled,
    output logic              running,
    output logic              allow,
    output logic              timed_out,
    output logic [CNT_W-1:0]  tmo
);
    logic armed;
    logic clr_ok;

    assign feed_ok = wr.feed && (wdata == KEY_FEED);
    assign clr_ok  = wr.stat && (wdata == KEY_STCLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled   <= 1'b0;
            running   <= 1'b0;
            armed     <= 1'b0;
            allow     <= 1'b0;
            timed_out <= 1'b0;
            tmo       <= CNT_W'(TMO_RESET);
        end else begin
            if (wr.tmo)
                tmo <= wdata[CNT_W-1:0];
            if (feed_ok)
                running <= 1'b1;
            if (wr.stop_a)
                armed <= (wdata == KEY_STOP_A);
            if (wr.stop_b) begin
                armed <= 1'b0;
                if (armed && wdata == KEY_STOP_B) begin
                    enabled <= 1'b0;
                    running <= 1'b0;
                end
            end
            if (wr.resume && wdata == KEY_RESUME && !enabled) begin
                enabled <= 1'b1;
                running <= 1'b0;
            end
            if (wr.dbg)
                allow <= wdata[0];
            if (expire)
                timed_out <= 1'b1;
            else if (clr_ok)
                timed_out <= 1'b0;
        end
    end

    // R5: a second key without an armed first key leaves the enable state alone
    assert_stop_needs_arm_R5: assert property (@(posedge clk) disable iff (rst)
        (wr.stop_b && !armed) |=> (enabled == $past(enabled)));

    // R8: the timed-out status stays until its own clear key
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (timed_out && !clr_ok) |=> timed_out);

    // R6: re-enabling leaves the counter idle until a feed
    assert_resume_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (wr.resume && wdata == KEY_RESUME && !enabled) |=> (enabled && !running));
endmodule

// File: rtl/wdt_irq.sv
`timescale 1ns/1ps
module wdt_irq (
    input  logic clk,
    input  logic rst,
    input  logic wr_evt,
    input  logic wr_msk,
    input  logic wr_frc,
    input  logic wbit,
    input  logic pre_fire,
    output logic evt,
    output logic msk,
    output logic frc,
    output logic irq
);
    logic ack;
    assign ack = wr_evt && wbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= 1'b0;
            msk <= 1'b0;
            frc <= 1'b0;
        end else begin
            if (wr_msk)
                msk <= wbit;
            if (wr_frc)
                frc <= wbit;
            if (pre_fire || frc)
                evt <= 1'b1;
            else if (ack)
                evt <= 1'b0;
        end
    end

    assign irq = evt && msk;

    // R10: the pre-expiry tick always leaves the event set
    assert_prefire_sets_R10: assert property (@(posedge clk) disable iff (rst)
        pre_fire |=> evt);

    // R11: a lone acknowledge clears the event
    assert_ack_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (ack && !pre_fire && !frc) |=> !evt);

    // R12: force holds the event set
    assert_force_holds_R12: assert property (@(posedge clk) disable iff (rst)
        frc |=> evt);
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int PRESCALE   = 320,
    parameter int RST_CYCLES = 16,
    parameter int TMO_RESET  = 6000,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_pulse,
    input  logic              dbg_active,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_reset
);
    logic             hi_zero;
    reg_sel_e         sel;
    wr_strobe_t       wr;
    logic             tick, run, feed_ok;
    logic             enabled, running, allow, timed_out;
    logic [CNT_W-1:0] tmo, cnt;
    logic             busy, pre_fire, expire;
    logic             evt, msk, frc;

    generate
        if (ADDR_W > 6) begin : g_hi
            assign hi_zero = (bus_addr[ADDR_W-1:6] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        sel       = map_addr(6'(bus_addr), hi_zero);
        wr.feed   = bus_wr && (sel == SEL_FEED);
        wr.tmo    = bus_wr && (sel == SEL_TMO);
        wr.stop_a = bus_wr && (sel == SEL_STOP_A);
        wr.stop_b = bus_wr && (sel == SEL_STOP_B);
        wr.stat   = bus_wr && (sel == SEL_STAT);
        wr.dbg    = bus_wr && (sel == SEL_DBG);
        wr.resume = bus_wr && (sel == SEL_RESUME);
        wr.ievt   = bus_wr && (sel == SEL_IEVT);
        wr.imsk   = bus_wr && (sel == SEL_IMSK);
        wr.ifrc   = bus_wr && (sel == SEL_IFRC);
    end

    assign run = enabled && running && (!dbg_active || allow);

    wdt_tick_gen #(.PRESCALE(PRESCALE)) tick_i (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .restart(feed_ok), .tick(tick)
    );

    wdt_ctl #(.TMO_RESET(TMO_RESET)) ctl_i (
        .clk(clk), .rst(rst), .wr(wr), .wdata(bus_wdata), .expire(expire),
        .feed_ok(feed_ok), .enabled(enabled), .running(running), .allow(allow),
        .timed_out(timed_out), .tmo(tmo)
    );

    wdt_countdown #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES), .TMO_RESET(TMO_RESET)) cnt_i (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .load(feed_ok), .reload_val(tmo),
        .cnt(cnt), .busy(busy), .pre_fire(pre_fire), .expire(expire), .sys_rst(wdt_reset)
    );

    wdt_irq irq_i (
        .clk(clk), .rst(rst), .wr_evt(wr.ievt), .wr_msk(wr.imsk), .wr_frc(wr.ifrc),
        .wbit(bus_wdata[0]), .pre_fire(pre_fire), .evt(evt), .msk(msk), .frc(frc),
        .irq(wdt_irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_TMO:    bus_rdata = {1'b0, tmo};
            SEL_STOP_B: bus_rdata = enabled ? '0 : SIG_STOPPED;
            SEL_STAT:   bus_rdata = timed_out ? SIG_EXPIRED : '0;
            SEL_CNT:    bus_rdata = {busy, cnt};
            SEL_DBG:    bus_rdata = {14'd0, dbg_active, allow};
            SEL_IEVT:   bus_rdata = {15'd0, evt};
            SEL_IMSK:   bus_rdata = {15'd0, msk};
            SEL_IFRC:   bus_rdata = {15'd0, frc};
            default:    bus_rdata = '0;
        endcase
    end

    // R13: debug without allow never lets the timer expire
    assert_debug_no_expire_R13: assert property (@(posedge clk) disable iff (rst)
        (dbg_active && !allow) |-> !expire);
endmodule

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRESC = 4;
    localparam int RSTC  = 3;
    localparam int NV    = 44;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_pulse = 1'b0;
    logic        dbg_active = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdt_irq, wdt_reset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_watchdog #(.PRESCALE(PRESC), .RST_CYCLES(RSTC), .TMO_RESET(6000), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .dbg_active(dbg_active),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .wdt_reset(wdt_reset)
    );

    // {write, addr, data-or-expected, requirement}
    localparam logic [32:0] VECS [0:NV-1] = '{
        {1'b0, 8'h0C, 16'hDABE, 8'd1},  // R1 stopped out of reset
        {1'b0, 8'h04, 16'h1770, 8'd1},  // R1 default timeout
        {1'b0, 8'h24, 16'h0000, 8'd1},  // R1 mask clear
        {1'b0, 8'h10, 16'h0000, 8'd1},  // R1 status normal
        {1'b0, 8'h20, 16'h0000, 8'd1},  // R1 no event
        {1'b0, 8'h14, 16'h1770, 8'd1},  // R1 counter at default
        {1'b1, 8'h04, 16'hFFFF, 8'd2},  // R2
        {1'b0, 8'h04, 16'h7FFF, 8'd2},  // R2 bit 15 dropped
        {1'b1, 8'h04, 16'h0005, 8'd2},
        {1'b0, 8'h04, 16'h0005, 8'd2},
        {1'b0, 8'h14, 16'h1770, 8'd2},  // R2 no reload from timeout write
        {1'b1, 8'h00, 16'h1234, 8'd3},  // R3 wrong feed key
        {1'b0, 8'h14, 16'h1770, 8'd3},
        {1'b1, 8'h24, 16'h0001, 8'd10}, // R10 mask
        {1'b0, 8'h24, 16'h0001, 8'd10},
        {1'b1, 8'h28, 16'h0001, 8'd12}, // R12 force on
        {1'b0, 8'h28, 16'h0001, 8'd12},
        {1'b0, 8'h20, 16'h0001, 8'd12},
        {1'b1, 8'h20, 16'h0001, 8'd11}, // R11 ack under force
        {1'b0, 8'h20, 16'h0001, 8'd11},
        {1'b1, 8'h28, 16'h0000, 8'd12},
        {1'b1, 8'h20, 16'h0001, 8'd11}, // R11 lone ack
        {1'b0, 8'h20, 16'h0000, 8'd11},
        {1'b1, 8'h24, 16'h0000, 8'd10},
        {1'b0, 8'h18, 16'h0000, 8'd13}, // R13
        {1'b1, 8'h18, 16'hFFFF, 8'd13},
        {1'b0, 8'h18, 16'h0001, 8'd13}, // R13 bit 1 read-only
        {1'b1, 8'h18, 16'h0000, 8'd13},
        {1'b1, 8'h1C, 16'hACED, 8'd6},  // R6 enable
        {1'b0, 8'h0C, 16'h0000, 8'd6},
        {1'b1, 8'h08, 16'h2BAD, 8'd5},  // R5 arm
        {1'b1, 8'h0C, 16'h1111, 8'd5},  // R5 wrong key disarms
        {1'b1, 8'h0C, 16'hCAFE, 8'd5},
        {1'b0, 8'h0C, 16'h0000, 8'd5},
        {1'b1, 8'h0C, 16'hCAFE, 8'd5},  // R5 no arm
        {1'b0, 8'h0C, 16'h0000, 8'd5},
        {1'b1, 8'h08, 16'h2BAD, 8'd5},
        {1'b1, 8'h0C, 16'hCAFE, 8'd5},
        {1'b0, 8'h0C, 16'hDABE, 8'd5},  // R5 stopped
        {1'b1, 8'h1C, 16'h1234, 8'd6},  // R6 wrong key
        {1'b0, 8'h0C, 16'hDABE, 8'd6},
        {1'b1, 8'h1C, 16'hACED, 8'd6},
        {1'b0, 8'h0C, 16'h0000, 8'd6},
        {1'b0, 8'h2C, 16'h0000, 8'd1}   // R1 unmapped
    };

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input int req, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL R%0d read %h got %h expected %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic chk(input int req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d port got %b expected %b", req, got, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ref_pulse = 1'b1;
            @(negedge clk) ref_pulse = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int highs;
        idle(3);
        @(negedge clk) rst = 1'b0;
        chk(1, wdt_irq, 1'b0);   // R1
        chk(1, wdt_reset, 1'b0); // R1

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][32])
                wr(VECS[i][31:24], VECS[i][23:8]);
            else
                rd(int'(VECS[i][7:0]), VECS[i][31:24], VECS[i][23:8]);
        end

        // R3, R9: feed reloads, flag then clean value
        wr(8'h00, 16'hFEED);
        rd(9, 8'h14, 16'h8005);
        rd(9, 8'h14, 16'h0005);
        // R4: one tick per four reference pulses
        pulses(4); idle(2); rd(4, 8'h14, 16'h0004);
        pulses(3); idle(2); rd(4, 8'h14, 16'h0004);
        pulses(1); idle(2); rd(4, 8'h14, 16'h0003);

        // R10: pre-expiry event one tick before reset
        wr(8'h24, 16'h0001);
        pulses(8); idle(2);
        rd(10, 8'h14, 16'h0001);
        rd(10, 8'h20, 16'h0000);
        chk(10, wdt_irq, 1'b0);
        pulses(4); idle(2);
        rd(10, 8'h14, 16'h0000);
        rd(10, 8'h20, 16'h0001);
        chk(10, wdt_irq, 1'b1);
        chk(7, wdt_reset, 1'b0);
        // R7: expiry pulse width, status, reload
        pulses(4);
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (wdt_reset) highs++;
        end
        checks++;
        if (highs != RSTC) begin
            fails++;
            $display("FAIL R7 reset width got %0d expected %0d", highs, RSTC);
        end
        rd(7, 8'h10, 16'hCFE8);
        rd(7, 8'h14, 16'h0005);
        wr(8'h20, 16'h0001);
        rd(11, 8'h20, 16'h0000);
        chk(11, wdt_irq, 1'b0);

        // R8: sticky status, keyed clear
        wr(8'h10, 16'h1234);
        rd(8, 8'h10, 16'hCFE8);
        wr(8'h10, 16'hE8B4);
        rd(8, 8'h10, 16'h0000);

        // R13: debug freeze and allow
        dbg_active = 1'b1;
        wr(8'h00, 16'hFEED);
        idle(2);
        rd(13, 8'h18, 16'h0002);
        pulses(8); idle(2);
        rd(13, 8'h14, 16'h0005);
        wr(8'h18, 16'h0001);
        rd(13, 8'h18, 16'h0003);
        pulses(4); idle(2);
        rd(13, 8'h14, 16'h0004);
        dbg_active = 1'b0;
        wr(8'h18, 16'h0000);

        // R5, R6: stopped timer frozen, restart waits for feed
        wr(8'h08, 16'h2BAD);
        wr(8'h0C, 16'hCAFE);
        rd(5, 8'h0C, 16'hDABE);
        pulses(4); idle(2);
        rd(5, 8'h14, 16'h0004);
        wr(8'h1C, 16'hACED);
        pulses(4); idle(2);
        rd(6, 8'h14, 16'h0004);
        wr(8'h00, 16'hFEED);
        idle(2);
        rd(6, 8'h14, 16'h0005);
        pulses(4); idle(2);
        rd(6, 8'h14, 16'h0004);

        // R11: acknowledge in the same cycle as the pre-expiry tick
        wr(8'h00, 16'hFEED);
        pulses(16); idle(2);
        rd(11, 8'h14, 16'h0001);
        pulses(3);
        @(negedge clk) ref_pulse = 1'b1;
        @(negedge clk);
        ref_pulse = 1'b0;
        bus_addr = 8'h20; bus_wdata = 16'h0001; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        rd(11, 8'h20, 16'h0001);
        rd(10, 8'h14, 16'h0000);
        wr(8'h20, 16'h0001);
        rd(11, 8'h20, 16'h0000);
        wr(8'h08, 16'h2BAD);
        wr(8'h0C, 16'hCAFE);
        rd(5, 8'h0C, 16'hDABE);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule